// File: doc/BRIEF.md
# Windowed Wide Residency Counter

This block measures how long a unit spends in a low-activity state. A 40-bit counter steps forward once per clock for as long as the residency-active input is high. When the input is low, the counter holds its value. When it reaches all ones it rolls over to zero, and no flag records the roll-over.

Software sees the count through a single 32-bit read register. A control register holds a range-select bit that slides this 32-bit view. With the bit clear, the view shows the least significant bits. With the bit set, it shows the most significant bits, which stretches the interval before the visible value wraps by a factor of 256 at a coarser resolution.

The control register takes masked writes. A control bit is changed only when the matching enable bit in the upper half of the written word is also set. Software can therefore flip the range bit without a read-modify-write. Reads are combinational and always show the slice chosen by the control register as it stands; nothing is latched between slices.

Top module: `rescnt_top`

## Requirements
- R1: While reset is asserted and immediately after it, the count is zero and the range-select bit is 0 (low view).
- R2: On each rising clock edge where `active_i` is 1, the count increases by exactly one.
- R3: On a rising clock edge where `active_i` is 0, the count keeps its value.
- R4: From all ones the count rolls over to zero on the next active edge, and nothing else changes.
- R5: Address 0 with range-select 0 reads count bits [REG_W-1:0] (bits 31:0 at default size).
- R6: Address 0 with range-select 1 reads count bits [CNT_W-1:CNT_W-REG_W] (bits 39:8 at default size), so the two views share bits 31:8.
- R7: A write to address 1 loads control bit 0 (range-select) from write-data bit 0 only when write-data bit REG_W/2 (bit 16 at default size) is 1. Otherwise the bit is left unchanged.
- R8: Address 1 reads the range-select bit at bit 0 and zero in all other bits.
- R9: A write to address 0 leaves the count unchanged. Addresses 2 and 3 read as zero.
- R10: A change of range-select is visible on the read data in the cycle right after the write edge, with no further delay and no latched copy of the other slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| active_i | input | 1 | Residency-active qualifier; the count advances while high |
| reg_wr_en_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 count view, 1 control |
| reg_wdata_i | input | REG_W (32) | Write data; upper half carries per-bit write enables |
| reg_rdata_o | output | REG_W (32) | Combinational read data for `reg_addr_i` |

## Verification
The counter is driven with a long unbroken active run and with a random duty cycle. The unbroken run separates a counter that only steps when qualified from one that stalls. The random duty cycle catches increments on idle edges. Control writes are sent with the enable bit clear and with it set, for both values of the range bit, which separates true masked-write behaviour from a plain load. A second instance with a 12-bit count and an 8-bit view is run through several roll-overs, which makes the wrap and the upper-slice position visible in both views.

// File: rtl/rescnt_pkg.sv
package rescnt_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_VIEW = 2'd0,
    REG_CTRL = 2'd1
  } reg_sel_e;

  // control bit positions (low half of the control word)
  localparam int CTL_RANGE = 0;
  localparam int CTL_N     = 1;

endpackage

// File: rtl/rescnt_counter.sv
module rescnt_counter #(
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en_i) begin
      cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (en_i) begin
      cnt_q <= cnt_d;
    end
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/rescnt_ctrl.sv
module rescnt_ctrl #(
  parameter int REG_W = 32,
  parameter int CTL_N = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [CTL_N-1:0] ctl_o
);

  localparam int MASK_OFS = REG_W / 2;

  logic [CTL_N-1:0] ctl_q;
  logic [CTL_N-1:0] ctl_d;
  logic [CTL_N-1:0] bit_we;

  generate
    for (genvar i = 0; i < CTL_N; i++) begin : g_bit
      always_comb begin
        bit_we[i] = wr_i & wdata_i[MASK_OFS+i];
        ctl_d[i]  = bit_we[i] ? wdata_i[i] : ctl_q[i];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (|bit_we) begin
      ctl_q <= ctl_d;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  assign ctl_o = ctl_q;

endmodule

// File: rtl/rescnt_window.sv
module rescnt_window #(
  parameter int CNT_W = 40,
  parameter int REG_W = 32
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic             hi_i,
  output logic [REG_W-1:0] view_o
);

  generate
    if (CNT_W > REG_W) begin : g_slide
      always_comb begin
        if (hi_i) begin
          view_o = count_i[CNT_W-1 -: REG_W];
        end else begin
          view_o = count_i[REG_W-1:0];
        end
      end
    end else begin : g_fit
      logic unused_hi;
      assign unused_hi = hi_i;
      assign view_o    = REG_W'(count_i);
    end
  endgenerate

endmodule

// File: rtl/rescnt_top.sv
module rescnt_top
  import rescnt_pkg::*;
#(
  parameter int CNT_W = 40,
  parameter int REG_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic              reg_wr_en_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o
);

  logic [CNT_W-1:0] count_q;
  logic [CTL_N-1:0] ctl_q;
  logic [REG_W-1:0] view;
  logic             ctl_wr;

  assign ctl_wr = reg_wr_en_i & (reg_addr_i == REG_CTRL);

  rescnt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (active_i),
    .count_o (count_q)
  );

  rescnt_ctrl #(.REG_W(REG_W), .CTL_N(CTL_N)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (ctl_wr),
    .wdata_i (reg_wdata_i),
    .ctl_o   (ctl_q)
  );

  rescnt_window #(.CNT_W(CNT_W), .REG_W(REG_W)) u_win (
    .count_i (count_q),
    .hi_i    (ctl_q[CTL_RANGE]),
    .view_o  (view)
  );

  always_comb begin
    case (reg_addr_i)
      REG_VIEW: reg_rdata_o = view;
      REG_CTRL: reg_rdata_o = REG_W'(ctl_q);
      default:  reg_rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/rescnt_chk.sv
module rescnt_chk #(
  parameter int CNT_W = 40,
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             active_i,
  input logic             reg_wr_en_i,
  input logic [1:0]       reg_addr_i,
  input logic [REG_W-1:0] reg_wdata_i,
  input logic [REG_W-1:0] reg_rdata_o,
  input logic [CNT_W-1:0] count,
  input logic             rng
);

  localparam int MASK_OFS = REG_W / 2;

  logic [CNT_W-1:0] cnt_inc;
  assign cnt_inc = count + {{(CNT_W-1){1'b0}}, 1'b1};

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |=> count == $past(cnt_inc));

  // R4: roll-over to zero is covered by cnt_inc truncation
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && (&count)) |=> count == '0);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> $stable(count));

  p_view_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == 2'd0 && !rng) |-> reg_rdata_o == count[REG_W-1:0]);

  p_view_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == 2'd0 && rng) |-> reg_rdata_o == count[CNT_W-1 -: REG_W]);

  p_mask_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en_i && reg_addr_i == 2'd1 && reg_wdata_i[MASK_OFS]) |=> $stable(rng));

  p_mask_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en_i && reg_addr_i == 2'd1 && reg_wdata_i[MASK_OFS]) |=> rng == $past(reg_wdata_i[0]));

  p_ctl_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == 2'd1) |-> reg_rdata_o == REG_W'(rng));

  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i[1]) |-> reg_rdata_o == '0);

endmodule

bind rescnt_top rescnt_chk #(.CNT_W(CNT_W), .REG_W(REG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .active_i    (active_i),
  .reg_wr_en_i (reg_wr_en_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .count       (count_q),
  .rng         (ctl_q[0])
);

// File: tb/rescnt_top_tb_top.sv
module rescnt_top_tb_top;

  localparam int BW = 40, BR = 32;
  localparam int SW = 12, SR = 8;

  logic clk, rst_n, active, wr_en;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic [7:0]  wdata_s;
  logic [31:0] rdata_b;
  logic [7:0]  rdata_s;

  int n_run, n_fail, cycles;
  logic done;

  logic [63:0] m_big, m_small;
  logic        m_rng;

  // small instance: mask bit 4, range bit 0
  assign wdata_s = {3'b000, wdata[16], 3'b000, wdata[0]};

  rescnt_top #(.CNT_W(BW), .REG_W(BR)) dut_i (
    .clk(clk), .rst_n(rst_n), .active_i(active), .reg_wr_en_i(wr_en),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata_b));

  rescnt_top #(.CNT_W(SW), .REG_W(SR)) dut_small (
    .clk(clk), .rst_n(rst_n), .active_i(active), .reg_wr_en_i(wr_en),
    .reg_addr_i(addr), .reg_wdata_i(wdata_s), .reg_rdata_o(rdata_s));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [63:0] exp_read(logic [63:0] cnt, logic rng,
                                           logic [1:0] a, int cw, int rw);
    logic [63:0] v;
    logic [63:0] m;
    m = (64'd1 << rw) - 64'd1;
    case (a)
      2'd0:    v = rng ? (cnt >> (cw - rw)) : cnt;
      2'd1:    v = {63'd0, rng};
      default: v = 64'd0;
    endcase
    return v & m;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic read_both(logic [1:0] a, string req);
    wr_en = 1'b0;
    addr  = a;
    #1;
    chk({req, " big"},   {32'd0, rdata_b}, exp_read(m_big,   m_rng, a, BW, BR));
    chk({req, " small"}, {56'd0, rdata_s}, exp_read(m_small, m_rng, a, SW, SR));
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) begin
      if (active) begin
        m_big   = (m_big + 64'd1)   & ((64'd1 << BW) - 64'd1);
        m_small = (m_small + 64'd1) & ((64'd1 << SW) - 64'd1);
      end
      if (wr_en && addr == 2'd1 && wdata[16]) m_rng = wdata[0];
    end
    #1;
    wr_en = 1'b0;
  endtask

  task automatic ctl_write(logic [31:0] d);
    wr_en = 1'b1; addr = 2'd1; wdata = d;
    tick();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m_big = '0; m_small = '0; m_rng = 1'b0;
    #1;
    read_both(2'd0, "R1 reset view");
    read_both(2'd1, "R1 reset ctl");
    tick(); tick();
    rst_n = 1'b1;
    #1;
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    n_run = 0; n_fail = 0; done = 1'b0;
    active = 1'b0; wr_en = 1'b0; addr = 2'd0; wdata = '0;
    #2;
    do_reset();
    read_both(2'd0, "R1 after release");
    read_both(2'd1, "R1 ctl after release");

    // R2 continuous count
    active = 1'b1;
    for (int i = 0; i < 300; i++) tick();
    active = 1'b0;
    read_both(2'd0, "R2 run of 300");
    // R3 hold
    for (int i = 0; i < 20; i++) tick();
    read_both(2'd0, "R3 idle hold");

    // R7 masked writes
    ctl_write(32'h0000_0001);
    read_both(2'd1, "R7 set without enable");
    ctl_write(32'h0001_0001);
    read_both(2'd1, "R7 set with enable");
    read_both(2'd0, "R6 high view");
    ctl_write(32'h0000_0000);
    read_both(2'd1, "R7 clear without enable");
    ctl_write(32'hFFFE_FFFE);
    read_both(2'd1, "R8 other bits zero");
    ctl_write(32'h0001_0000);
    read_both(2'd0, "R10 view after clear");
    read_both(2'd1, "R7 clear with enable");

    // R9 write to count address and unmapped reads
    wr_en = 1'b1; addr = 2'd0; wdata = 32'hFFFF_FFFF;
    tick();
    read_both(2'd0, "R9 write to view ignored");
    read_both(2'd2, "R9 unmapped 2");
    read_both(2'd3, "R9 unmapped 3");

    // R4 wrap of small instance
    active = 1'b1;
    while (m_small != 64'hFFF) tick();
    active = 1'b0;
    read_both(2'd0, "R4 all ones low view");
    ctl_write(32'h0001_0001);
    read_both(2'd0, "R6 all ones high view");
    active = 1'b1;
    tick();
    active = 1'b0;
    read_both(2'd0, "R4 rolled to zero");
    ctl_write(32'h0001_0000);
    read_both(2'd0, "R5 low view after roll");

    // random mix
    for (int i = 0; i < 6000; i++) begin
      active = ($urandom % 4) != 0;
      wr_en  = ($urandom % 8) == 0;
      addr   = 2'($urandom % 4);
      wdata  = $urandom;
      tick();
      read_both(2'($urandom % 4), "R5 R6 R2 random");
    end

    // mid-run reset
    active = 1'b0;
    do_reset();
    read_both(2'd0, "R1 second reset");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule